// File: doc/BRIEF.md
# Bus Master Backoff Sequencer

This block drives one memory or I/O bus cycle at a time for a single bus master over a 64-bit data path. A caller presents a cycle request made of an address in 8-byte units, byte enables, direction, memory/IO select, data/code select, a writeback flag and a burst flag. When the block takes the request it raises the address strobe for one clock. It then collects one beat per clock in which `rdy` is high: four beats for a burst, one for a single transfer. Read data is handed on per beat, and write data is driven while the data phase lasts.

Three hold inputs let system logic take the bus away. `backoff` acts at once. It abandons the running cycle, floats every bus output from the next clock, and keeps the beats already finished. When `backoff` drops, the cycle is issued again with a new address strobe, starting from the first beat not yet done. `arb_hold` lets the running cycle finish, then floats the bus and raises `hlda`. `addr_hold` blocks only new cycles that are not writebacks. `backoff` wins when several holds are active together.

The state machine has five states. IDLE waits for work. ADDR is the strobe clock. DATA collects beats. BOFF floats the bus for a backoff. HOLD floats the bus with `hlda` high. The transitions are:
- IDLE→ADDR on accept; IDLE→HOLD on `arb_hold`.
- ADDR→DATA always.
- DATA→IDLE on the last beat; DATA→HOLD on the last beat while `arb_hold` is high.
- BOFF→ADDR on release with a cycle still pending ("replay"); BOFF→HOLD or BOFF→IDLE on release with nothing pending.
- HOLD→IDLE when `arb_hold` drops.
- Any state→BOFF while `backoff` is high.

Top module: `bob_backoff_seq`

## Requirements
- R1: During reset and just after it, the block is idle. `ads`, `hlda` and `data_oe` are low, and `bus_oe` is high.
- R2: A request is taken in a clock where `req_valid` and `req_ready` are both high. `ads` is then high for exactly the next clock and carries the request's address, byte enables and attributes. `req_ready` stays low until that cycle has fully finished, so only one cycle is ever outstanding.
- R3: In the data phase, a beat completes in each clock where `rdy` is high and `backoff` is low. `beat_valid` flags the beat. A burst (`req_burst`=1) takes four beats and a single transfer takes one. `cyc_done` is high together with the last beat.
- R4: When `backoff` is high at a clock edge, `ads`, `bus_oe` and `data_oe` are low from the next clock on. A `rdy` in a clock where `backoff` is high completes no beat.
- R5: Beats finished before a backoff are kept. In the clock after `backoff` is sampled low, `ads` rises again with the same address. `beat_idx` then continues from the number of beats already kept, counting from 0.
- R6: The bus stays floated (`bus_oe` low) for as many clocks as `backoff` stays high.
- R7: `hlda` rises only after the current cycle's last beat, or from idle one clock after `arb_hold` is sampled. While `hlda` is high, `bus_oe` and `data_oe` are low. `hlda` falls in the clock after `arb_hold` is sampled low.
- R8: `req_ready` is low whenever `backoff` or `arb_hold` is high, so any request, writebacks included, waits for their release. While `addr_hold` is high, only a request with `req_wb`=1 can be taken.
- R9: When `backoff` and `arb_hold` are high together, `backoff` wins: `hlda` is low in the next clock and the bus is floated.
- R10: On a write, `data_oe` is high in each data-phase clock and `bus_dout` equals the request's `req_wdata`. On a read, `beat_data` equals `bus_din` in the clock of each beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Cycle request present |
| req_ready | output | 1 | Request can be taken this clock |
| req_addr | input | ADDR_W (29) | Cycle address in 8-byte units |
| req_be | input | DATA_W/8 (8) | Byte enables |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mio | input | 1 | 1 = memory, 0 = I/O |
| req_dc | input | 1 | 1 = data, 0 = code |
| req_wb | input | 1 | Request is a writeback |
| req_burst | input | 1 | 1 = four-beat burst, 0 = single beat |
| req_wdata | input | DATA_W (64) | Write data |
| backoff | input | 1 | Immediate backoff |
| addr_hold | input | 1 | Address hold |
| arb_hold | input | 1 | Arbitration hold request |
| hlda | output | 1 | Hold acknowledge |
| rdy | input | 1 | Beat ready from the bus |
| bus_din | input | DATA_W (64) | Read data from the bus |
| ads | output | 1 | Address strobe |
| bus_oe | output | 1 | Enable for the address, byte-enable and cycle-definition outputs |
| data_oe | output | 1 | Enable for the write data outputs |
| bus_addr | output | ADDR_W (29) | Cycle address |
| bus_be | output | DATA_W/8 (8) | Cycle byte enables |
| bus_wr | output | 1 | Cycle direction |
| bus_mio | output | 1 | Cycle memory/IO select |
| bus_dc | output | 1 | Cycle data/code select |
| bus_dout | output | DATA_W (64) | Write data to the bus |
| beat_valid | output | 1 | A beat completes this clock |
| beat_idx | output | $clog2(BURST_LEN) (2) | Index of the completing beat |
| beat_data | output | DATA_W (64) | Read data of the completing beat |
| cyc_done | output | 1 | The last beat of the cycle completes this clock |

## Verification
Some results are combinational on the inputs of the same clock: `beat_valid`, `beat_idx`, `beat_data`, `cyc_done` and `req_ready`. Others appear one clock after the edge that samples their cause: `ads` after an accept or a backoff release, the float after `backoff`, and the rise and fall of `hlda`. The bench changes inputs just after each rising edge. At each rising edge its reference model moves to the state it expects for the coming clock. It compares every output at the falling edge, so a combinational result is checked in the clock that causes it and a registered result in the clock after. Directed checks mark the backoff interval, the joint backoff-and-hold case and the hold-gated requests.

// File: rtl/bob_pkg.sv
package bob_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // waiting for work
        ST_ADDR = 3'd1,   // strobe clock
        ST_DATA = 3'd2,   // collecting beats
        ST_BOFF = 3'd3,   // floated by backoff
        ST_HOLD = 3'd4    // floated, hold acknowledged
    } bob_state_t;

    // Latched cycle attributes
    typedef struct packed {
        logic wr;
        logic mio;
        logic dc;
        logic wb;
        logic burst;
    } bob_attr_t;

endpackage

// File: rtl/bob_req_reg.sv
module bob_req_reg
    import bob_pkg::*;
#(
    parameter int ADDR_W = 29,
    parameter int DATA_W = 64,
    localparam int BE_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              cyc_done,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [BE_W-1:0]   in_be,
    input  bob_attr_t         in_attr,
    input  logic [DATA_W-1:0] in_wdata,
    output logic [ADDR_W-1:0] q_addr,
    output logic [BE_W-1:0]   q_be,
    output bob_attr_t         q_attr,
    output logic [DATA_W-1:0] q_wdata,
    output logic              pend
);

    // The cycle's address and attributes stay put through aborts and replays.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_addr  <= '0;
            q_be    <= '0;
            q_attr  <= '0;
            q_wdata <= '0;
        end else if (accept) begin
            q_addr  <= in_addr;
            q_be    <= in_be;
            q_attr  <= in_attr;
            q_wdata <= in_wdata;
        end
    end

    // A cycle is pending from the accept until its final beat.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pend <= 1'b0;
        else if (accept)   pend <= 1'b1;
        else if (cyc_done) pend <= 1'b0;
    end

endmodule

// File: rtl/bob_beat_ctr.sv
module bob_beat_ctr #(
    parameter int BURST_LEN = 4,
    localparam int CNT_W = $clog2(BURST_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             beat_ok,
    input  logic             burst,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);

    localparam logic [CNT_W-1:0] LAST_BURST = CNT_W'(BURST_LEN - 1);

    // Counts kept beats; an abort leaves it untouched so a replay resumes here.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (accept)  cnt <= '0;
        else if (beat_ok) cnt <= cnt + 1'b1;
    end

    always_comb begin
        last = burst ? (cnt == LAST_BURST) : (cnt == '0);
    end

endmodule

// File: rtl/bob_fsm.sv
module bob_fsm
    import bob_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       backoff,
    input  logic       arb_hold,
    input  logic       addr_hold,
    input  logic       req_valid,
    input  logic       req_wb,
    input  logic       rdy,
    input  logic       last_beat,
    input  logic       pend,
    input  logic       cur_write,
    output bob_state_t state,
    output logic       req_ready,
    output logic       accept,
    output logic       beat_ok,
    output logic       cyc_done,
    output logic       ads,
    output logic       bus_oe,
    output logic       data_oe,
    output logic       hlda
);

    bob_state_t nxt;

    // Next state; backoff outranks every other condition.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (backoff)       nxt = ST_BOFF;
                else if (arb_hold) nxt = ST_HOLD;
                else if (accept)   nxt = ST_ADDR;
            end
            ST_ADDR: begin
                nxt = backoff ? ST_BOFF : ST_DATA;
            end
            ST_DATA: begin
                if (backoff)        nxt = ST_BOFF;
                else if (cyc_done)  nxt = arb_hold ? ST_HOLD : ST_IDLE;
            end
            ST_BOFF: begin
                if (!backoff) begin
                    if (pend)          nxt = ST_ADDR;
                    else if (arb_hold) nxt = ST_HOLD;
                    else               nxt = ST_IDLE;
                end
            end
            ST_HOLD: begin
                if (backoff)        nxt = ST_BOFF;
                else if (!arb_hold) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Outputs
    always_comb begin
        req_ready = (state == ST_IDLE) && !backoff && !arb_hold
                    && (!addr_hold || req_wb);
        accept    = req_ready && req_valid;
        beat_ok   = (state == ST_DATA) && rdy && !backoff;
        cyc_done  = beat_ok && last_beat;
        ads       = (state == ST_ADDR);
        bus_oe    = (state != ST_BOFF) && (state != ST_HOLD);
        data_oe   = (state == ST_DATA) && cur_write;
        hlda      = (state == ST_HOLD);
    end

endmodule

// File: rtl/bob_backoff_seq.sv
module bob_backoff_seq
    import bob_pkg::*;
#(
    parameter int ADDR_W    = 29,
    parameter int DATA_W    = 64,
    parameter int BURST_LEN = 4,
    localparam int BE_W  = DATA_W / 8,
    localparam int CNT_W = $clog2(BURST_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic              req_write,
    input  logic              req_mio,
    input  logic              req_dc,
    input  logic              req_wb,
    input  logic              req_burst,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              backoff,
    input  logic              addr_hold,
    input  logic              arb_hold,
    output logic              hlda,
    input  logic              rdy,
    input  logic [DATA_W-1:0] bus_din,
    output logic              ads,
    output logic              bus_oe,
    output logic              data_oe,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BE_W-1:0]   bus_be,
    output logic              bus_wr,
    output logic              bus_mio,
    output logic              bus_dc,
    output logic [DATA_W-1:0] bus_dout,
    output logic              beat_valid,
    output logic [CNT_W-1:0]  beat_idx,
    output logic [DATA_W-1:0] beat_data,
    output logic              cyc_done
);

    bob_state_t state;
    bob_attr_t  in_attr;
    bob_attr_t  q_attr;
    logic       accept;
    logic       beat_ok;
    logic       last_beat;
    logic       pend;

    always_comb begin
        in_attr.wr    = req_write;
        in_attr.mio   = req_mio;
        in_attr.dc    = req_dc;
        in_attr.wb    = req_wb;
        in_attr.burst = req_burst;
    end

    bob_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .backoff   (backoff),
        .arb_hold  (arb_hold),
        .addr_hold (addr_hold),
        .req_valid (req_valid),
        .req_wb    (req_wb),
        .rdy       (rdy),
        .last_beat (last_beat),
        .pend      (pend),
        .cur_write (q_attr.wr),
        .state     (state),
        .req_ready (req_ready),
        .accept    (accept),
        .beat_ok   (beat_ok),
        .cyc_done  (cyc_done),
        .ads       (ads),
        .bus_oe    (bus_oe),
        .data_oe   (data_oe),
        .hlda      (hlda)
    );

    bob_req_reg #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .cyc_done (cyc_done),
        .in_addr  (req_addr),
        .in_be    (req_be),
        .in_attr  (in_attr),
        .in_wdata (req_wdata),
        .q_addr   (bus_addr),
        .q_be     (bus_be),
        .q_attr   (q_attr),
        .q_wdata  (bus_dout),
        .pend     (pend)
    );

    bob_beat_ctr #(
        .BURST_LEN (BURST_LEN)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .beat_ok (beat_ok),
        .burst   (q_attr.burst),
        .cnt     (beat_idx),
        .last    (last_beat)
    );

    always_comb begin
        bus_wr     = q_attr.wr;
        bus_mio    = q_attr.mio;
        bus_dc     = q_attr.dc;
        beat_valid = beat_ok;
        beat_data  = bus_din;
    end

endmodule

// File: rtl/bob_backoff_chk.sv
module bob_backoff_chk (
    input logic clk,
    input logic rst_n,
    input logic backoff,
    input logic arb_hold,
    input logic req_valid,
    input logic req_ready,
    input logic ads,
    input logic bus_oe,
    input logic data_oe,
    input logic hlda,
    input logic beat_valid
);

    // R2: strobe lasts a single clock
    p_ads_one_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ads |=> !ads);

    // R2: an accepted request strobes in the next clock
    p_accept_to_ads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ads);

    // R4: float one clock after backoff
    p_float_after_boff_r4: assert property (@(posedge clk) disable iff (!rst_n)
        backoff |=> (!bus_oe && !data_oe && !ads));

    // R4: no beat in the clock after a sampled backoff
    p_no_beat_after_boff_r4: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> !$past(backoff));

    // R7: acknowledged hold keeps the bus floated
    p_hlda_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> (!bus_oe && !data_oe));

    // R7: acknowledge drops one clock after hold is released
    p_hlda_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hlda && !arb_hold) |=> !hlda);

    // R7: acknowledge only follows a sampled hold
    p_hlda_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hlda) |-> $past(arb_hold));

    // R9: backoff outranks hold
    p_boff_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
        backoff |=> !hlda);

endmodule

bind bob_backoff_seq bob_backoff_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .backoff    (backoff),
    .arb_hold   (arb_hold),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .ads        (ads),
    .bus_oe     (bus_oe),
    .data_oe    (data_oe),
    .hlda       (hlda),
    .beat_valid (beat_valid)
);

// File: tb/tb_bob_backoff_seq.sv
module tb_bob_backoff_seq;

    localparam int AW = 29;
    localparam int DW = 64;
    localparam int BW = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [BW-1:0] req_be = '0;
    logic          req_write = 1'b0, req_mio = 1'b1, req_dc = 1'b1;
    logic          req_wb = 1'b0, req_burst = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic          backoff = 1'b0, addr_hold = 1'b0, arb_hold = 1'b0;
    logic          hlda;
    logic          rdy = 1'b0;
    logic [DW-1:0] bus_din = '0;
    logic          ads, bus_oe, data_oe;
    logic [AW-1:0] bus_addr;
    logic [BW-1:0] bus_be;
    logic          bus_wr, bus_mio, bus_dc;
    logic [DW-1:0] bus_dout;
    logic          beat_valid;
    logic [1:0]    beat_idx;
    logic [DW-1:0] beat_data;
    logic          cyc_done;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    int rdy_gap = 0;
    int rc = 0;

    bob_backoff_seq dut (.*);

    always #2 clk = ~clk;   // 250 MHz

    // ready and read data pattern
    always @(posedge clk) begin
        #1;
        rc++;
        rdy = ((rc % (rdy_gap + 1)) == 0);
        bus_din = {32'h5EED_0000, 32'(rc)};
    end

    // ---------------- reference model ----------------
    // modes: 0 idle, 1 strobe, 2 data, 3 backed off, 4 hold
    int            m_mode = 0;
    int            m_kept = 0;
    int            m_len = 1;
    bit            m_pend = 0;
    bit            m_wr = 0, m_mio = 0, m_dc = 0;
    logic [AW-1:0] m_addr = '0;
    logic [BW-1:0] m_be = '0;
    logic [DW-1:0] m_wdata = '0;

    function automatic bit may_take();
        return (m_mode == 0) && !backoff && !arb_hold && (!addr_hold || req_wb);
    endfunction

    function automatic bit beat_now();
        return (m_mode == 2) && rdy && !backoff;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_pend = 0; m_kept = 0; m_len = 1;
        end else begin
            bit acc, bt, fin;
            int nm;
            acc = may_take() && req_valid;
            bt  = beat_now();
            fin = bt && (m_kept + 1 == m_len);
            nm  = m_mode;
            if (backoff) nm = 3;
            else if (m_mode == 0) nm = arb_hold ? 4 : (acc ? 1 : 0);
            else if (m_mode == 1) nm = 2;
            else if (m_mode == 2) begin if (fin) nm = arb_hold ? 4 : 0; end
            else if (m_mode == 3) nm = m_pend ? 1 : (arb_hold ? 4 : 0);
            else nm = arb_hold ? 4 : 0;
            if (acc) begin
                m_addr = req_addr; m_be = req_be; m_wr = req_write;
                m_mio = req_mio; m_dc = req_dc; m_wdata = req_wdata;
                m_kept = 0; m_len = req_burst ? 4 : 1; m_pend = 1;
            end
            if (bt)  m_kept++;
            if (fin) m_pend = 0;
            m_mode = nm;
        end
    end

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison at the falling edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit e_bv;
            e_bv = beat_now();
            chk("R2 ads", 64'(ads), 64'(m_mode == 1));
            chk("R4 bus_oe", 64'(bus_oe), 64'(!(m_mode == 3 || m_mode == 4)));
            chk("R7 hlda", 64'(hlda), 64'(m_mode == 4));
            chk("R10 data_oe", 64'(data_oe), 64'(m_mode == 2 && m_wr));
            chk("R3 beat_valid", 64'(beat_valid), 64'(e_bv));
            chk("R3 cyc_done", 64'(cyc_done), 64'(e_bv && (m_kept + 1 == m_len)));
            chk("R8 req_ready", 64'(req_ready), 64'(may_take()));
            if (e_bv) begin
                chk("R5 beat_idx", 64'(beat_idx), 64'(m_kept[1:0]));
                if (!m_wr) chk("R10 beat_data", beat_data, bus_din);
            end
            if (m_mode == 1) begin
                chk("R5 bus_addr", 64'(bus_addr), 64'(m_addr));
                chk("R2 bus_be", 64'(bus_be), 64'(m_be));
                chk("R2 attrs", 64'({bus_wr, bus_mio, bus_dc}), 64'({m_wr, m_mio, m_dc}));
            end
            if (m_mode == 2 && m_wr) chk("R10 bus_dout", bus_dout, m_wdata);
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_req(logic [AW-1:0] a, bit wr, bit burst, bit wb);
        req_addr  = a;
        req_be    = BW'(a[7:0] | 8'h01);
        req_write = wr;
        req_mio   = a[0];
        req_dc    = a[1];
        req_burst = burst;
        req_wb    = wb;
        req_wdata = {a[15:0], 48'hDA7A_0000_BEEF} ^ 64'(a);
    endtask

    task automatic issue(logic [AW-1:0] a, bit wr, bit burst, bit wb);
        set_req(a, wr, burst, wb);
        req_valid = 1'b1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (may_take()) break;
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200; i++) begin
            if (m_mode == 0 && !m_pend) break;
            tick(1);
        end
    endtask

    task automatic wait_kept(int k);
        for (int i = 0; i < 100; i++) begin
            if (m_kept >= k) break;
            tick(1);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 190000);
        n_bad++;
        $display("FAIL watchdog: run did not end");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            chk("R1 ads", 64'(ads), 64'd0);
            chk("R1 hlda", 64'(hlda), 64'd0);
            chk("R1 bus_oe", 64'(bus_oe), 64'd1);
            chk("R1 data_oe", 64'(data_oe), 64'd0);
        end
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 req_ready", 64'(req_ready), 64'd1);
        tick(1);

        // R3: burst read, ready every clock
        rdy_gap = 0;
        issue(29'h0012_3400, 0, 1, 0);
        wait_idle();
        // R10/R3: single write with wait states
        rdy_gap = 1;
        issue(29'h0000_0ABD, 1, 0, 0);
        wait_idle();
        // R3: burst write with wait states
        rdy_gap = 2;
        issue(29'h0055_0006, 1, 1, 0);
        wait_idle();

        // R5/R6: backoff mid-burst, held six clocks
        rdy_gap = 0;
        issue(29'h0ACE_0010, 0, 1, 0);
        wait_kept(2);
        backoff = 1'b1;
        repeat (6) begin
            tick(1);
            @(negedge clk);
            chk("R6 floated while backed off", 64'(bus_oe), 64'd0);
        end
        tick(1);
        backoff = 1'b0;
        wait_idle();

        // R4: backoff in the strobe clock
        issue(29'h0033_0021, 1, 1, 0);
        backoff = 1'b1;
        tick(2);
        backoff = 1'b0;
        wait_idle();

        // R7: hold during a burst
        rdy_gap = 2;
        issue(29'h0044_0002, 0, 1, 0);
        tick(2);
        arb_hold = 1'b1;
        for (int i = 0; i < 50; i++) begin
            if (m_mode == 4) break;
            tick(1);
        end
        @(negedge clk);
        chk("R7 hlda after completion", 64'(hlda), 64'd1);
        tick(3);
        arb_hold = 1'b0;
        tick(1);
        @(negedge clk);
        chk("R7 hlda released", 64'(hlda), 64'd0);
        tick(2);

        // R9: backoff and hold together
        backoff = 1'b1;
        arb_hold = 1'b1;
        tick(1);
        @(negedge clk);
        chk("R9 hlda under backoff", 64'(hlda), 64'd0);
        chk("R9 floated", 64'(bus_oe), 64'd0);
        tick(2);
        backoff = 1'b0;
        tick(1);
        @(negedge clk);
        chk("R7 hlda after backoff release", 64'(hlda), 64'd1);
        arb_hold = 1'b0;
        tick(2);

        // R8: address hold blocks plain cycles, passes writebacks
        rdy_gap = 0;
        addr_hold = 1'b1;
        set_req(29'h0066_0000, 0, 1, 0);
        req_valid = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk("R8 blocked by addr hold", 64'(req_ready), 64'd0);
            tick(1);
        end
        req_valid = 1'b0;
        issue(29'h0066_0040, 1, 1, 1);
        wait_idle();
        addr_hold = 1'b0;

        // R8: writeback deferred by arbitration hold
        arb_hold = 1'b1;
        tick(2);
        set_req(29'h0077_0008, 1, 0, 1);
        req_valid = 1'b1;
        repeat (2) begin
            @(negedge clk);
            chk("R8 deferred by hold", 64'(req_ready), 64'd0);
            tick(1);
        end
        arb_hold = 1'b0;
        issue(29'h0077_0008, 1, 0, 1);
        wait_idle();

        // R5/R7: backoff with hold pending, replay then hold
        issue(29'h0088_0030, 0, 1, 0);
        wait_kept(1);
        backoff = 1'b1;
        arb_hold = 1'b1;
        tick(3);
        backoff = 1'b0;
        for (int i = 0; i < 50; i++) begin
            if (m_mode == 4) break;
            tick(1);
        end
        @(negedge clk);
        chk("R5 replay finished before hold", 64'(m_pend), 64'd0);
        arb_hold = 1'b0;
        tick(4);

        finish_run();
    end

endmodule